// File: doc/BRIEF.md
# Tape Command Validation Dispatcher

This block sits between a tape controller's command register and its motion/transfer engine. Each time software raises GO, it examines the requested function together with the drive's condition: attached or not, moving, write-locked, at either end of tape, formatter in error. It also looks at the tape-control fields: density, format and frame count, and whether a frame count has been loaded. It then produces one cycle of control strobes for the surrounding register file.

A command can end in one of three ways. It can be refused, which raises exactly one error bit, sets attention, clears GO and requests an interrupt. It can complete at once, as drive clear, no-op and read-in preset do. Otherwise it is handed to the downstream engine with a start strobe carrying the function code. Rejection rules differ per function family. The family decides which position, lock, frame-count, format and density checks apply and in which order. For data transfers the block also tells the drive which density to remember when the drive has not yet learned one.

Top module: `tape_cmd_gate`

## Requirements
- R1: After reset all outputs are 0. A GO sampled at a rising edge produces its strobes during exactly the following clock cycle. With GO low at an edge, every output is 0 in the next cycle.
- R2: Function codes are NOP=0, UNLOAD=1, REWIND=2, DCLR=3, PRESET=4, ERASE=5, WRMARK=6, SPCF=7, SPCR=8, WCHKF=9, WCHKR=10, WRITE=11, READF=12, READR=13. Any code other than DCLR is refused with the illegal-function error when the formatter-error input or the moving input is high.
- R3: The error strobe vector uses bit0 for illegal function, bit1 for drive unsafe, bit2 for not executable and bit3 for format error. A refusal raises exactly one of these bits, together with attn_set, go_clr and irq. A refusal raises neither start nor attn_clr.
- R4: sac_clr is raised whenever a command passes the R2 gate. attn_clr is raised when such a command is also not refused.
- R5: DCLR is accepted even when the drive is moving or the formatter is in error. It raises drv_clr and go_clr, and it raises no irq.
- R6: NOP raises only go_clr (with sac_clr and attn_clr). PRESET raises preset and go_clr.
- R7: REWIND and UNLOAD on an unattached drive are refused as unsafe. Otherwise they raise start with their code and go_clr, and they raise neither done_clr nor stat_clr.
- R8: SPCF and SPCR check in this order. First, an unattached drive gives unsafe. Second, not-executable is given for SPCF at end of tape, for SPCR at beginning of tape, or for either when the frame-count-set input is low. When accepted they raise start and stat_clr, without go_clr or done_clr.
- R9: READR and WCHKR at beginning of tape are refused as not executable. WRITE is refused as not executable when frame-count-set is low, or when density is 3 (NRZI) and the frame count is above 65525. These checks come before the lock and attach checks.
- R10: WRITE, WRMARK and ERASE on a write-locked drive are refused as not executable. This check follows the R9 checks.
- R11: Each transfer code (5, 6, 9 to 13) is checked after R9 and R10 in this order. An unattached drive gives unsafe. A format code outside {0, 2, 3, 12, 13} gives a format error. A density other than 3 or 4 gives not executable.
- R12: An accepted transfer raises done_clr, stat_clr and start with its code. It raises den_learn with den_val equal to the requested density only when den_known is low.
- R13: Codes 14 to 31 are refused with the illegal-function error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Command issue pulse |
| fn_i | input | 5 | Requested function code |
| den_i | input | DEN_W | Requested density code |
| fmt_i | input | FMT_W | Requested format code |
| fcnt_i | input | FC_W | Frame count register (two's complement) |
| fc_set_i | input | 1 | Frame count has been loaded |
| bot_i | input | 1 | Drive at beginning of tape |
| eot_i | input | 1 | Drive at end of tape |
| fmtr_err_i | input | 1 | Formatter error summary bit |
| wlock_i | input | 1 | Drive write-locked |
| attached_i | input | 1 | Medium present on drive |
| moving_i | input | 1 | Drive already in motion |
| den_known_i | input | 1 | Drive has a learned density |
| err_set_o | output | 4 | Error bit set strobes (see R3) |
| attn_set_o | output | 1 | Set attention |
| attn_clr_o | output | 1 | Clear attention |
| sac_clr_o | output | 1 | Clear slave-address-changed |
| drv_clr_o | output | 1 | Drive clear: zero errors, clear frame-count-set and status, stop motion |
| preset_o | output | 1 | Force 800 NRZI density and rewind unit 0 |
| go_clr_o | output | 1 | Clear GO |
| done_clr_o | output | 1 | Clear DONE |
| stat_clr_o | output | 1 | Clear transfer error byte, parity/transfer errors, tape mark and ID status |
| start_o | output | 1 | Launch downstream engine |
| start_fn_o | output | 5 | Function launched (0 when start_o is low) |
| den_learn_o | output | 1 | Record density on the drive |
| den_val_o | output | DEN_W | Density to record (0 when den_learn_o is low) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest outcomes to reach are the deep transfer checks: the format, density and density-learning decisions. They are only reached when every earlier guard passes at once. That means no motion, no formatter error, not at beginning of tape for reverse codes, a loaded and long enough frame count for write, no lock, and an attached drive. Random stimulus therefore biases each guard input toward its benign value, so that a useful fraction of commands reach those checks. Directed cases pin the write frame-count limit on both sides of 65525, and also cover a reverse read at beginning of tape on an unattached drive and drive clear while moving.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int FNW = 5;

  localparam logic [FNW-1:0] FN_NOP    = 5'd0;
  localparam logic [FNW-1:0] FN_UNLOAD = 5'd1;
  localparam logic [FNW-1:0] FN_REWIND = 5'd2;
  localparam logic [FNW-1:0] FN_DCLR   = 5'd3;
  localparam logic [FNW-1:0] FN_PRESET = 5'd4;
  localparam logic [FNW-1:0] FN_ERASE  = 5'd5;
  localparam logic [FNW-1:0] FN_WRMARK = 5'd6;
  localparam logic [FNW-1:0] FN_SPCF   = 5'd7;
  localparam logic [FNW-1:0] FN_SPCR   = 5'd8;
  localparam logic [FNW-1:0] FN_WCHKF  = 5'd9;
  localparam logic [FNW-1:0] FN_WCHKR  = 5'd10;
  localparam logic [FNW-1:0] FN_WRITE  = 5'd11;
  localparam logic [FNW-1:0] FN_READF  = 5'd12;
  localparam logic [FNW-1:0] FN_READR  = 5'd13;

  localparam int EB_ILF = 0;
  localparam int EB_UNS = 1;
  localparam int EB_NXF = 2;
  localparam int EB_FER = 3;
  localparam int EBW    = 4;

  typedef struct packed {
    logic clr;
    logic nop;
    logic rip;
    logic rew;
    logic spf;
    logic spr;
    logic rrev;
    logic wr;
    logic wmark;
    logic rfwd;
    logic bad;
  } fn_class_t;

  typedef struct packed {
    logic [EBW-1:0] err;
    logic attn_set;
    logic attn_clr;
    logic sac_clr;
    logic drv_clr;
    logic preset;
    logic go_clr;
    logic done_clr;
    logic stat_clr;
    logic start;
    logic learn;
    logic irq;
  } verdict_t;
endpackage

// File: rtl/tcg_classify.sv
module tcg_classify
  import tcg_pkg::*;
(
  input  logic [FNW-1:0] fn,
  output fn_class_t      cls
);
  always_comb begin
    cls = '0;
    case (fn)
      FN_DCLR:              cls.clr   = 1'b1;
      FN_NOP:               cls.nop   = 1'b1;
      FN_PRESET:            cls.rip   = 1'b1;
      FN_REWIND, FN_UNLOAD: cls.rew   = 1'b1;
      FN_SPCF:              cls.spf   = 1'b1;
      FN_SPCR:              cls.spr   = 1'b1;
      FN_READR, FN_WCHKR:   cls.rrev  = 1'b1;
      FN_WRITE:             cls.wr    = 1'b1;
      FN_WRMARK, FN_ERASE:  cls.wmark = 1'b1;
      FN_READF, FN_WCHKF:   cls.rfwd  = 1'b1;
      default:              cls.bad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/tcg_rules.sv
module tcg_rules
  import tcg_pkg::*;
#(
  parameter int DEN_W      = 3,
  parameter int FMT_W      = 4,
  parameter int FC_W       = 16,
  parameter logic [(1<<FMT_W)-1:0] FMT_MASK = 16'h300D,
  parameter int DEN_NRZI   = 3,
  parameter int DEN_PE     = 4,
  parameter int MIN_FRAMES = 11
) (
  input  fn_class_t        cls,
  input  logic [DEN_W-1:0] den,
  input  logic [FMT_W-1:0] fmt,
  input  logic [FC_W-1:0]  fcnt,
  input  logic             fc_set,
  input  logic             bot,
  input  logic             eot,
  input  logic             fmtr_err,
  input  logic             wlock,
  input  logic             attached,
  input  logic             moving,
  input  logic             den_known,
  output verdict_t         v,
  output logic             gate_ok,
  output logic             refused
);
  localparam longint FC_SPAN = longint'(1) << FC_W;
  localparam logic [FC_W-1:0] FC_LIMIT = FC_W'(FC_SPAN - longint'(MIN_FRAMES));

  function automatic logic fmt_ok(input logic [FMT_W-1:0] f);
    return FMT_MASK[f];
  endfunction

  function automatic logic den_ok(input logic [DEN_W-1:0] d);
    return (d == DEN_W'(DEN_NRZI)) || (d == DEN_W'(DEN_PE));
  endfunction

  function automatic logic too_short(input logic [DEN_W-1:0] d, input logic [FC_W-1:0] c);
    return (d == DEN_W'(DEN_NRZI)) && (c > FC_LIMIT);
  endfunction

  logic [EBW-1:0] rej;
  logic           xfer;
  logic           edge_hit;

  always_comb begin
    v        = '0;
    rej      = '0;
    xfer     = cls.rrev | cls.wr | cls.wmark | cls.rfwd;
    edge_hit = cls.spf ? eot : bot;
    gate_ok  = cls.clr | ~(fmtr_err | moving);

    if (!gate_ok) begin
      rej[EB_ILF] = 1'b1;
    end else if (cls.clr) begin
      v.drv_clr = 1'b1;
      v.go_clr  = 1'b1;
    end else if (cls.nop) begin
      v.go_clr = 1'b1;
    end else if (cls.rip) begin
      v.preset = 1'b1;
      v.go_clr = 1'b1;
    end else if (cls.rew) begin
      if (!attached) rej[EB_UNS] = 1'b1;
      else begin
        v.start  = 1'b1;
        v.go_clr = 1'b1;
      end
    end else if (cls.spf | cls.spr) begin
      if (!attached)                rej[EB_UNS] = 1'b1;
      else if (edge_hit || !fc_set) rej[EB_NXF] = 1'b1;
      else begin
        v.start    = 1'b1;
        v.stat_clr = 1'b1;
      end
    end else if (xfer) begin
      if (cls.rrev && bot)                            rej[EB_NXF] = 1'b1;
      else if (cls.wr && (!fc_set || too_short(den, fcnt))) rej[EB_NXF] = 1'b1;
      else if ((cls.wr || cls.wmark) && wlock)       rej[EB_NXF] = 1'b1;
      else if (!attached)                             rej[EB_UNS] = 1'b1;
      else if (!fmt_ok(fmt))                          rej[EB_FER] = 1'b1;
      else if (!den_ok(den))                          rej[EB_NXF] = 1'b1;
      else begin
        v.done_clr = 1'b1;
        v.stat_clr = 1'b1;
        v.start    = 1'b1;
        v.learn    = ~den_known;
      end
    end else if (cls.bad) begin
      rej[EB_ILF] = 1'b1;
    end

    refused    = |rej;
    v.err      = rej;
    v.sac_clr  = gate_ok;
    v.attn_clr = gate_ok & ~refused;
    if (refused) begin
      v.go_clr   = 1'b1;
      v.attn_set = 1'b1;
      v.irq      = 1'b1;
    end
  end
endmodule

// File: rtl/tcg_outreg.sv
module tcg_outreg
  import tcg_pkg::*;
#(
  parameter int DEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  verdict_t         v,
  input  logic [FNW-1:0]   fn,
  input  logic [DEN_W-1:0] den,
  output verdict_t         q,
  output logic [FNW-1:0]   fn_q,
  output logic [DEN_W-1:0] den_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      q     <= '0;
      fn_q  <= '0;
      den_q <= '0;
    end else begin
      q     <= v;
      fn_q  <= v.start ? fn : '0;
      den_q <= v.learn ? den : '0;
    end
  end
endmodule

// File: rtl/tape_cmd_gate.sv
module tape_cmd_gate
  import tcg_pkg::*;
#(
  parameter int DEN_W      = 3,
  parameter int FMT_W      = 4,
  parameter int FC_W       = 16,
  parameter logic [(1<<FMT_W)-1:0] FMT_MASK = 16'h300D,
  parameter int DEN_NRZI   = 3,
  parameter int DEN_PE     = 4,
  parameter int MIN_FRAMES = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [4:0]       fn_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [FC_W-1:0]  fcnt_i,
  input  logic             fc_set_i,
  input  logic             bot_i,
  input  logic             eot_i,
  input  logic             fmtr_err_i,
  input  logic             wlock_i,
  input  logic             attached_i,
  input  logic             moving_i,
  input  logic             den_known_i,
  output logic [3:0]       err_set_o,
  output logic             attn_set_o,
  output logic             attn_clr_o,
  output logic             sac_clr_o,
  output logic             drv_clr_o,
  output logic             preset_o,
  output logic             go_clr_o,
  output logic             done_clr_o,
  output logic             stat_clr_o,
  output logic             start_o,
  output logic [4:0]       start_fn_o,
  output logic             den_learn_o,
  output logic [DEN_W-1:0] den_val_o,
  output logic             irq_o
);
  fn_class_t cls;
  verdict_t  v;
  verdict_t  q;
  logic      gate_ok;
  logic      refused;

  tcg_classify u_cls (.fn(fn_i), .cls(cls));

  tcg_rules #(
    .DEN_W(DEN_W), .FMT_W(FMT_W), .FC_W(FC_W), .FMT_MASK(FMT_MASK),
    .DEN_NRZI(DEN_NRZI), .DEN_PE(DEN_PE), .MIN_FRAMES(MIN_FRAMES)
  ) u_rules (
    .cls(cls), .den(den_i), .fmt(fmt_i), .fcnt(fcnt_i), .fc_set(fc_set_i),
    .bot(bot_i), .eot(eot_i), .fmtr_err(fmtr_err_i), .wlock(wlock_i),
    .attached(attached_i), .moving(moving_i), .den_known(den_known_i),
    .v(v), .gate_ok(gate_ok), .refused(refused)
  );

  tcg_outreg #(.DEN_W(DEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(go_i), .v(v), .fn(fn_i), .den(den_i),
    .q(q), .fn_q(start_fn_o), .den_q(den_val_o)
  );

  assign err_set_o   = q.err;
  assign attn_set_o  = q.attn_set;
  assign attn_clr_o  = q.attn_clr;
  assign sac_clr_o   = q.sac_clr;
  assign drv_clr_o   = q.drv_clr;
  assign preset_o    = q.preset;
  assign go_clr_o    = q.go_clr;
  assign done_clr_o  = q.done_clr;
  assign stat_clr_o  = q.stat_clr;
  assign start_o     = q.start;
  assign den_learn_o = q.learn;
  assign irq_o       = q.irq;
endmodule

// File: rtl/tcg_chk.sv
module tcg_chk
  import tcg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       go_i,
  input logic [4:0] fn_i,
  input logic       moving_i,
  input logic       fmtr_err_i,
  input logic       wlock_i,
  input logic       gate_ok,
  input logic       refused,
  input logic [3:0] err_set_o,
  input logic       attn_set_o,
  input logic       attn_clr_o,
  input logic       drv_clr_o,
  input logic       go_clr_o,
  input logic       done_clr_o,
  input logic       stat_clr_o,
  input logic       start_o,
  input logic       irq_o
);
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> (err_set_o == 4'd0 && !start_o && !go_clr_o && !attn_set_o && !irq_o && !drv_clr_o));

  a_r1_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (go_clr_o || start_o));

  a_r2_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && fn_i != FN_DCLR && (moving_i || fmtr_err_i)) |=> (err_set_o == 4'b0001));

  a_r3_refusal_form: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && refused) |=> (attn_set_o && irq_o && go_clr_o && !start_o && !attn_clr_o
                           && $countones(err_set_o) == 1));

  a_r3_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_set_o));

  a_r4_attn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && gate_ok && !refused) |=> (attn_clr_o && !attn_set_o));

  a_r5_clear_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && fn_i == FN_DCLR) |=> (drv_clr_o && go_clr_o && !irq_o));

  a_r10_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && wlock_i && (fn_i == FN_WRITE || fn_i == FN_WRMARK || fn_i == FN_ERASE)) |=> !start_o);

  a_r12_done_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr_o |-> (start_o && stat_clr_o && !go_clr_o));
endmodule

bind tape_cmd_gate tcg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .fn_i(fn_i), .moving_i(moving_i),
  .fmtr_err_i(fmtr_err_i), .wlock_i(wlock_i), .gate_ok(gate_ok), .refused(refused),
  .err_set_o(err_set_o), .attn_set_o(attn_set_o), .attn_clr_o(attn_clr_o),
  .drv_clr_o(drv_clr_o), .go_clr_o(go_clr_o), .done_clr_o(done_clr_o),
  .stat_clr_o(stat_clr_o), .start_o(start_o), .irq_o(irq_o)
);

// File: tb/sim_tape_cmd_gate.sv
module sim_tape_cmd_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [4:0] fn = '0;
  logic [2:0] den = '0;
  logic [3:0] fmt = '0;
  logic [15:0] fcnt = '0;
  logic fc_set = 1'b0, bot = 1'b0, eot = 1'b0, ferr = 1'b0, wlock = 1'b0;
  logic att = 1'b0, mov = 1'b0, known = 1'b0;

  logic [3:0] err_set;
  logic attn_set, attn_clr, sac_clr, drv_clr, preset, go_clr, done_clr, stat_clr, start, learn, irq;
  logic [4:0] start_fn;
  logic [2:0] den_val;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tape_cmd_gate u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go), .fn_i(fn), .den_i(den), .fmt_i(fmt),
    .fcnt_i(fcnt), .fc_set_i(fc_set), .bot_i(bot), .eot_i(eot), .fmtr_err_i(ferr),
    .wlock_i(wlock), .attached_i(att), .moving_i(mov), .den_known_i(known),
    .err_set_o(err_set), .attn_set_o(attn_set), .attn_clr_o(attn_clr), .sac_clr_o(sac_clr),
    .drv_clr_o(drv_clr), .preset_o(preset), .go_clr_o(go_clr), .done_clr_o(done_clr),
    .stat_clr_o(stat_clr), .start_o(start), .start_fn_o(start_fn), .den_learn_o(learn),
    .den_val_o(den_val), .irq_o(irq)
  );

  function automatic logic [22:0] observed();
    return {err_set, attn_set, attn_clr, sac_clr, drv_clr, preset, go_clr, done_clr,
            stat_clr, start, learn, irq, start_fn, den_val};
  endfunction

  // Expected strobes, built from the requirement text.
  function automatic logic [22:0] model(input logic [4:0] f, input logic [2:0] d,
      input logic [3:0] fm, input logic [15:0] fc, input logic fcs, input logic b,
      input logic e, input logic fe, input logic wl, input logic at, input logic mv,
      input logic kn);
    logic [3:0] er;
    logic as_, ac, sc, dc, pr, gc, dn, sr, st, ln, iq;
    logic [4:0] sf;
    logic [2:0] dv;
    logic vfmt, vden, shrt;
    er = 0; as_ = 0; ac = 0; sc = 0; dc = 0; pr = 0; gc = 0; dn = 0; sr = 0;
    st = 0; ln = 0; iq = 0; sf = 0; dv = 0;
    vfmt = (fm == 0) || (fm == 2) || (fm == 3) || (fm == 12) || (fm == 13);
    vden = (d == 3) || (d == 4);
    shrt = (d == 3) && (fc > 16'd65525);
    if (f != 5'd3 && (fe || mv)) er = 4'b0001;
    else begin
      sc = 1;
      case (f)
        5'd3: begin dc = 1; gc = 1; end
        5'd0: gc = 1;
        5'd4: begin pr = 1; gc = 1; end
        5'd1, 5'd2: if (!at) er = 4'b0010; else begin st = 1; gc = 1; sf = f; end
        5'd7, 5'd8: begin
          if (!at) er = 4'b0010;
          else if (((f == 5'd7) ? e : b) || !fcs) er = 4'b0100;
          else begin st = 1; sr = 1; sf = f; end
        end
        5'd5, 5'd6, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: begin
          if ((f == 5'd10 || f == 5'd13) && b) er = 4'b0100;
          else if (f == 5'd11 && (!fcs || shrt)) er = 4'b0100;
          else if ((f == 5'd5 || f == 5'd6 || f == 5'd11) && wl) er = 4'b0100;
          else if (!at) er = 4'b0010;
          else if (!vfmt) er = 4'b1000;
          else if (!vden) er = 4'b0100;
          else begin
            dn = 1; sr = 1; st = 1; sf = f;
            if (!kn) begin ln = 1; dv = d; end
          end
        end
        default: er = 4'b0001;
      endcase
    end
    if (er != 0) begin as_ = 1; gc = 1; iq = 1; end
    else ac = sc;
    return {er, as_, ac, sc, dc, pr, gc, dn, sr, st, ln, iq, sf, dv};
  endfunction

  function automatic string req_of(input logic [4:0] f, input logic fe, input logic mv);
    if (f != 5'd3 && (fe || mv)) return "R2";
    case (f)
      5'd3: return "R5";
      5'd0, 5'd4: return "R6";
      5'd1, 5'd2: return "R7";
      5'd7, 5'd8: return "R8";
      5'd5, 5'd6, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [4:0] f, input logic [2:0] d, input logic [3:0] fm,
      input logic [15:0] fc, input logic fcs, input logic b, input logic e, input logic fe,
      input logic wl, input logic at, input logic mv, input logic kn, input string tag);
    logic [22:0] exp;
    @(negedge clk);
    fn = f; den = d; fmt = fm; fcnt = fc; fc_set = fcs; bot = b; eot = e;
    ferr = fe; wlock = wl; att = at; mov = mv; known = kn; go = 1'b1;
    exp = model(f, d, fm, fc, fcs, b, e, fe, wl, at, mv, kn);
    @(negedge clk);
    go = 1'b0;
    check(tag, observed(), exp);
    @(negedge clk);
    check("R1 quiet after pulse", observed(), 23'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 reset state", observed(), 23'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", observed(), 23'd0);

    // directed corner cases
    run_cmd(5'd3, 3, 0, 0, 1, 0, 0, 1, 0, 1, 1, 1, "R5 clear while moving");
    run_cmd(5'd12, 3, 0, 0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 read while moving");
    run_cmd(5'd0, 3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R6 nop");
    run_cmd(5'd4, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, "R6 preset");
    run_cmd(5'd2, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, "R7 rewind unattached");
    run_cmd(5'd1, 3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R7 unload");
    run_cmd(5'd7, 3, 0, 0, 1, 0, 1, 0, 0, 1, 0, 1, "R8 space fwd at eot");
    run_cmd(5'd8, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R8 space rev no fc");
    run_cmd(5'd8, 3, 0, 0, 1, 0, 1, 0, 0, 1, 0, 1, "R8 space rev ok at eot");
    run_cmd(5'd13, 3, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, "R9 read rev at bot unattached");
    run_cmd(5'd11, 3, 12, 16'd65525, 1, 0, 0, 0, 0, 1, 0, 1, "R9 write nrzi at limit");
    run_cmd(5'd11, 3, 12, 16'd65526, 1, 0, 0, 0, 0, 1, 0, 1, "R9 write nrzi short");
    run_cmd(5'd11, 4, 12, 16'd65530, 1, 0, 0, 0, 0, 1, 0, 1, "R9 write pe short ok");
    run_cmd(5'd6, 3, 12, 0, 1, 0, 0, 0, 1, 0, 0, 1, "R10 mark locked");
    run_cmd(5'd12, 3, 1, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R11 bad format");
    run_cmd(5'd9, 5, 13, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R11 bad density");
    run_cmd(5'd12, 4, 2, 0, 1, 0, 0, 0, 0, 1, 0, 0, "R12 learn density");
    run_cmd(5'd10, 3, 3, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R12 known density");
    run_cmd(5'd20, 3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R13 unsupported code");
    run_cmd(5'd14, 3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R13 first unsupported");
    run_cmd(5'd5, 3, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R4 erase accepted");

    // constrained random
    for (int i = 0; i < 500; i++) begin
      logic [4:0] f;
      logic [2:0] d;
      logic [3:0] fm;
      logic [15:0] fc;
      f  = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(14, 31)) : 5'($urandom_range(0, 13));
      d  = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(3, 4));
      case ($urandom_range(0, 5))
        0: fm = 4'($urandom_range(0, 15));
        1: fm = 4'd2;
        2: fm = 4'd3;
        3: fm = 4'd12;
        4: fm = 4'd13;
        default: fm = 4'd0;
      endcase
      fc = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(65520, 65535)) : 16'($urandom);
      run_cmd(f, d, fm, fc, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
              $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 4) == 0,
              $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 0,
              req_of(f, ferr, mov));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule